// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block keeps a position count for a two-channel incremental encoder. The count runs from zero up to a ceiling that software sets. A two-bit source field chooses what advances the count. In the first source the count steps once per clock cycle. In the second and third sources, both edges of one channel are counted and the level of the other channel sets the direction. In the fourth source, every edge of both channels is counted, which gives four counts per encoder cycle, and the direction follows the phase order of the two channels.

Both encoder inputs pass through a two-flop synchroniser before edge detection. Software controls the block through a single-cycle register write port with a combinational read port. The register port, the count, the direction flag and the wrap pulse are plain control and status pins. No data stream flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `qenc_counter`

Register map. Address 0 is the control register: bit 0 enable, bits 2:1 source, bit 3 direction (read-only), bit 4 ceiling buffering, bit 5 update strobe (write-only, reads 0). Address 1 is the count. Address 2 is the active ceiling. Address 3 reads 0.

## Requirements
- R1: After reset the control register reads 0, the count reads 0, the ceiling reads all ones and the wrap pulse is low.
- R2: With source 0 and enable set, the count rises by one on every clock cycle, and the encoder inputs have no effect.
- R3: With source 1, each rising or falling edge of channel A steps the count. The step is up when the new A level differs from the B level and down otherwise. Edges on channel B leave the count unchanged.
- R4: With source 2, each edge of channel B steps the count. The step is up when the new B level equals the A level and down otherwise. Edges on channel A leave the count unchanged.
- R5: With source 3, every single-channel edge steps the count, so the sequence AB = 00,10,11,01 counts up and the reverse counts down. A simultaneous change of both channels is dropped.
- R6: Control bit 3 holds the direction of the most recent step: 0 for up, 1 for down. Source 0 steps set it to 0.
- R7: An up step from the ceiling gives 0 and a down step from 0 gives the ceiling. Each wrap raises the wrap output for exactly one cycle.
- R8: A count write is taken only if the value does not exceed the active ceiling. A larger value is ignored.
- R9: With buffering off (bit 4 = 0), a ceiling write takes effect on the next cycle. If the count then lies above the new ceiling, the count becomes 0. The count never exceeds the active ceiling.
- R10: With buffering on, a ceiling write is held in a shadow register. Writing bit 5 = 1 copies the shadow into the active ceiling and clears the count. Bit 5 always reads 0.
- R11: With enable clear, the count and the direction hold and encoder edges are ignored. Register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Read data for reg_addr, combinational |
| count_o | output | CW | Current count |
| dir_o | output | 1 | Direction of last step (1 = down) |
| wrap_o | output | 1 | One-cycle pulse on overflow or underflow |

## Verification
The hardest cases to reach from the ports are the wraps in both directions and the source-dependent dropping of edges. They need the encoder walked across the ceiling and across zero, in both directions and in every source. The stimulus walks a Gray-code position model forward past a small ceiling, then back below zero, then forward again. For each move the bench computes which edges occurred, whether the selected source counts them, and in which direction. In the clock source, the number of enabled cycles is swept over a range longer than two ceiling periods, and the expected count and wrap total are taken modulo the ceiling plus one.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [1:0] {
    SRC_CLK = 2'd0,
    SRC_A   = 2'd1,
    SRC_B   = 2'd2,
    SRC_AB  = 2'd3
  } src_mode_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_CEIL  = 2'd2;

  localparam int BIT_EN      = 0;
  localparam int BIT_SRC_LO  = 1;
  localparam int BIT_DIR     = 3;
  localparam int BIT_BUF     = 4;
  localparam int BIT_UPDATE  = 5;
  localparam int CTRL_W      = 6;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int CH     = 2,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] din,
  output logic [CH-1:0] lvl,
  output logic [CH-1:0] edge_o
);
  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe <= '0;
        prev <= 1'b0;
      end else begin
        pipe <= {pipe[STAGES-2:0], din[c]};
        prev <= pipe[STAGES-1];
      end
    end

    assign lvl[c]    = pipe[STAGES-1];
    assign edge_o[c] = pipe[STAGES-1] ^ prev;
  end
endmodule

// File: rtl/qenc_step.sv
module qenc_step
  import qenc_pkg::*;
(
  input  src_mode_e  mode,
  input  logic       en,
  input  logic [1:0] lvl,
  input  logic [1:0] edge_i,
  output logic       step,
  output logic       up
);
  logic a_up, b_up;

  // A edge counts up when new A differs from B; B edge counts up when new B equals A
  assign a_up = lvl[0] ^ lvl[1];
  assign b_up = ~(lvl[0] ^ lvl[1]);

  always_comb begin
    step = 1'b0;
    up   = 1'b1;
    unique case (mode)
      SRC_CLK: begin
        step = en;
        up   = 1'b1;
      end
      SRC_A: begin
        step = en & edge_i[0];
        up   = a_up;
      end
      SRC_B: begin
        step = en & edge_i[1];
        up   = b_up;
      end
      SRC_AB: begin
        step = en & (edge_i[0] ^ edge_i[1]);
        up   = edge_i[0] ? a_up : b_up;
      end
      default: begin
        step = 1'b0;
        up   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/qenc_regs.sv
module qenc_regs
  import qenc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic          en,
  output src_mode_e     mode,
  output logic          buf_en,
  output logic [CW-1:0] ceil,
  output logic          ceil_load,
  output logic [CW-1:0] ceil_next,
  output logic          upd
);
  logic          wr_ctrl, wr_ceil;
  logic [CW-1:0] shadow_q, ceil_q;

  assign wr_ctrl   = wr && (addr == ADDR_CTRL);
  assign wr_ceil   = wr && (addr == ADDR_CEIL);
  assign upd       = wr_ctrl && wdata[BIT_UPDATE];
  assign ceil_load = (wr_ceil && !buf_en) || upd;
  assign ceil_next = wr_ceil ? wdata : shadow_q;
  assign ceil      = ceil_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      mode     <= SRC_CLK;
      buf_en   <= 1'b0;
      shadow_q <= '1;
      ceil_q   <= '1;
    end else begin
      if (wr_ctrl) begin
        en     <= wdata[BIT_EN];
        mode   <= src_mode_e'(wdata[BIT_SRC_LO +: 2]);
        buf_en <= wdata[BIT_BUF];
      end
      if (wr_ceil) shadow_q <= wdata;
      if (ceil_load) ceil_q <= ceil_next;
    end
  end

  p_buffered_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ceil && buf_en) |=> $stable(ceil_q));
  p_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ceil && !buf_en) |=> (ceil_q == $past(wdata)));
endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          up,
  input  logic          clr,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic [CW-1:0] ceil_i,
  input  logic          ceil_load,
  input  logic [CW-1:0] ceil_next,
  output logic [CW-1:0] cnt,
  output logic          dir,
  output logic          wrap
);
  logic [CW-1:0] eff, cnt_q;
  logic          dir_q, wrap_q;

  assign eff = ceil_load ? ceil_next : ceil_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (clr) begin
        cnt_q <= '0;
      end else if (ld && (ld_val <= eff)) begin
        cnt_q <= ld_val;
      end else if (cnt_q > eff) begin
        cnt_q <= '0;
      end else if (step) begin
        dir_q <= ~up;
        if (up) begin
          if (cnt_q == eff) begin
            cnt_q  <= '0;
            wrap_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (cnt_q == '0) begin
            cnt_q  <= eff;
            wrap_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign cnt  = cnt_q;
  assign dir  = dir_q;
  assign wrap = wrap_q;

  p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ceil_i);
  p_wrap_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (cnt_q == '0 || cnt_q == ceil_i));
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic [CW-1:0] count_o,
  output logic          dir_o,
  output logic          wrap_o
);
  localparam int PAD = CW - CTRL_W;

  logic [1:0]    lvl, edges;
  logic          en, buf_en, ceil_load, upd, step, up, ld;
  src_mode_e     mode;
  logic [CW-1:0] ceil, ceil_next;

  qenc_sync #(.CH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({enc_b, enc_a}), .lvl(lvl), .edge_o(edges)
  );

  qenc_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en(en), .mode(mode), .buf_en(buf_en), .ceil(ceil),
    .ceil_load(ceil_load), .ceil_next(ceil_next), .upd(upd)
  );

  qenc_step u_step (
    .mode(mode), .en(en), .lvl(lvl), .edge_i(edges), .step(step), .up(up)
  );

  assign ld = reg_wr && (reg_addr == ADDR_COUNT);

  qenc_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .step(step), .up(up), .clr(upd),
    .ld(ld), .ld_val(reg_wdata), .ceil_i(ceil), .ceil_load(ceil_load),
    .ceil_next(ceil_next), .cnt(count_o), .dir(dir_o), .wrap(wrap_o)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:  reg_rdata = {{PAD{1'b0}}, 1'b0, buf_en, dir_o, mode, en};
      ADDR_COUNT: reg_rdata = count_o;
      ADDR_CEIL:  reg_rdata = ceil;
      default:    reg_rdata = '0;
    endcase
  end

  p_clk_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == SRC_CLK && !reg_wr && count_o < ceil) |=>
      (count_o == $past(count_o) + 1'b1));
  p_a_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_A && step) |-> edges[0]);
  p_b_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_B && step) |-> edges[1]);
  p_no_double_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SRC_AB && edges == 2'b11) |-> !step);
  p_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reg_wr) |=> (dir_o == !$past(up)));
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && reg_wdata <= ceil) |=> (count_o == $past(reg_wdata)));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (count_o == '0));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reg_wr) |=> ($stable(count_o) && $stable(dir_o)));
endmodule

// File: tb/test_qenc_counter.sv
module test_qenc_counter;
  localparam int CW = 8;
  localparam logic [1:0] A_CTRL = 2'd0, A_CNT = 2'd1, A_CEIL = 2'd2;
  localparam int EN = 1, BUFB = 16, UPD = 32;

  logic clk = 1'b0, rst_n = 1'b0, enc_a = 1'b0, enc_b = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0, reg_rdata, count_o;
  logic dir_o, wrap_o;

  int total = 0, fails = 0, wrap_seen = 0, exp_wraps = 0;
  int exp_cnt = 0, exp_dir = 0, ceil_v = 0, pos = 0;

  always #5 clk = ~clk;

  qenc_counter #(.CW(CW)) i_qenc_counter (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count_o(count_o), .dir_o(dir_o), .wrap_o(wrap_o)
  );

  always @(negedge clk) if (rst_n && wrap_o) wrap_seen++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = CW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    reg_addr = a; #1; d = int'(reg_rdata);
  endtask

  // Gray position: 0=00 1=10 2=11 3=01 as (A,B)
  function automatic logic pa(input int p); return (p == 1 || p == 2); endfunction
  function automatic logic pb(input int p); return (p == 2 || p == 3); endfunction

  task automatic move(input int delta, input int mode, input bit en);
    int np; logic na, nb, ea, eb, cnt, up;
    np = (pos + delta) & 3;
    na = pa(np); nb = pb(np);
    ea = (na != enc_a); eb = (nb != enc_b);
    cnt = 1'b0; up = 1'b1;
    if (mode == 1 && ea) begin cnt = 1'b1; up = (na != nb); end
    if (mode == 2 && eb) begin cnt = 1'b1; up = (na == nb); end
    if (mode == 3 && (ea ^ eb)) begin cnt = 1'b1; up = ea ? (na != nb) : (na == nb); end
    enc_a = na; enc_b = nb; pos = np;
    repeat (4) @(negedge clk);
    if (cnt && en) begin
      exp_dir = up ? 0 : 1;
      if (up) begin
        if (exp_cnt == ceil_v) begin exp_cnt = 0; exp_wraps++; end else exp_cnt++;
      end else begin
        if (exp_cnt == 0) begin exp_cnt = ceil_v; exp_wraps++; end else exp_cnt--;
      end
    end
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int v;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_CNT, v);  chk("R1 count", v, 0);
    rd(A_CEIL, v); chk("R1 ceiling", v, 255);
    chk("R1 wrap", int'(wrap_o), 0);

    // R8 / R11: count writes with enable clear
    wr(A_CEIL, 5); ceil_v = 5;
    wr(A_CNT, 2);  rd(A_CNT, v); chk("R8 accepted write", v, 2);
    wr(A_CNT, 7);  rd(A_CNT, v); chk("R8 write above ceiling ignored", v, 2);
    wr(A_CNT, 5);  rd(A_CNT, v); chk("R8 write at ceiling", v, 5);
    // R9 immediate ceiling shrink
    wr(A_CEIL, 3); rd(A_CEIL, v); chk("R9 ceiling immediate", v, 3);
    rd(A_CNT, v);  chk("R9 count cleared above ceiling", v, 0);
    // R10 buffered ceiling
    wr(A_CTRL, BUFB); wr(A_CNT, 2);
    wr(A_CEIL, 7); rd(A_CEIL, v); chk("R10 ceiling buffered", v, 3);
    rd(A_CNT, v);  chk("R10 count kept", v, 2);
    wr(A_CTRL, BUFB | UPD);
    rd(A_CEIL, v); chk("R10 ceiling after update", v, 7);
    rd(A_CNT, v);  chk("R10 count cleared by update", v, 0);
    rd(A_CTRL, v); chk("R10 strobe reads 0", v & UPD, 0);
    ceil_v = 7;
    // R11 enable clear ignores edges
    wr(A_CTRL, 3 << 1); wr(A_CNT, 1); exp_cnt = 1;
    for (int i = 0; i < 4; i++) move(1, 3, 1'b0);
    rd(A_CNT, v); chk("R11 count holds while disabled", v, 1);
    rd(A_CTRL, v); chk("R11 direction holds", (v >> 3) & 1, exp_dir);

    // R3 R4 R5 sweep with small ceiling
    wr(A_CEIL, 4); ceil_v = 4;
    for (int m = 1; m <= 3; m++) begin
      tag = (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
      wr(A_CTRL, UPD); exp_cnt = 0;
      wr(A_CTRL, EN | (m << 1));
      for (int i = 0; i < 40; i++) begin
        move((i < 14 || i >= 34) ? 1 : -1, m, 1'b1);
        rd(A_CNT, v); chk(tag, v, exp_cnt);
        rd(A_CTRL, v); chk("R6 direction", (v >> 3) & 1, exp_dir);
      end
      @(negedge clk);
      chk("R7 wrap pulses", wrap_seen, exp_wraps);
    end
    // R5 simultaneous change dropped
    wr(A_CNT, 2); exp_cnt = 2;
    enc_a = ~enc_a; enc_b = ~enc_b; pos = (pos + 2) & 3;
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R5 double change dropped", v, 2);

    // R2 clock source sweep, encoder toggling ignored
    wr(A_CEIL, 6); ceil_v = 6;
    for (int m = 0; m < 16; m++) begin
      wr(A_CTRL, UPD);
      wr(A_CTRL, EN);
      enc_b = ~enc_b;
      repeat (m) @(negedge clk);
      wr(A_CTRL, 0);
      enc_b = ~enc_b;
      exp_wraps += (m + 1) / 7;
      rd(A_CNT, v); chk("R2 clock count", v, (m + 1) % 7);
      rd(A_CTRL, v); chk("R6 clock direction up", (v >> 3) & 1, 0);
    end
    repeat (2) @(negedge clk);
    chk("R7 wrap pulses clock source", wrap_seen, exp_wraps);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule